// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block decides when a DMA-style network device writes its status block to host memory and interrupts the host. Receive and transmit traffic each have a tick counter and a pending-event counter. When a tick counter reaches its programmed threshold, or a pending count reaches its programmed maximum, the engine requests a status block write. Once that write is acknowledged, it requests a host interrupt. Both the write and the interrupt are request/acknowledge handshakes with the surrounding logic. The actual DMA and the message signalled interrupt bus transfer happen outside this block.

Software controls the engine through one 32-bit mode register. The register holds the run control, a self-clearing soft reset and a self-clearing immediate-update request. It also holds an attention enable for errors, per-direction modes that keep a tick counter parked until the first event arrives, and two switches that suppress the interrupt after a forced update. The remaining fields select the status block size and supply the low bits of the interrupt message data. Clearing the run bit lets any update or interrupt in flight finish. The run bit keeps reading back as one until the engine has actually stopped.

Top module: `intr_coal_engine`

## Requirements
- R1: After reset the mode register reads 0, and `upd_req`, `irq_req` and `attn` are low.
- R2: Mode register bits 31:13 ignore writes and read as zero. The other fields read back what was written.
- R3: Writing one to bit 0 resets the engine: the sequencer returns to the stopped state and all tick and pending counts clear. Bit 0 reads one for one cycle and then clears itself.
- R4: Bit 1 runs the engine. When it is cleared during an update or interrupt handshake, that handshake still completes. Bit 1 reads back one until the engine is stopped, and a stopped engine issues no further updates.
- R5: With no other trigger, when a direction's tick threshold L is nonzero, `upd_req` rises L+2 cycles after the write that sets bit 1. A threshold of 0 disables that trigger.
- R6: When a direction's pending-event count reaches its nonzero maximum M, an update is requested. With M-1 events, no update is requested. M may be the full-scale value of the counter.
- R7: When bit 9 (receive) or bit 10 (transmit) is set, that direction's tick counter stays parked until one of its events arrives. After that event, `upd_req` rises L+1 cycles after the event cycle.
- R8: Writing one to bit 3 forces an update followed by an interrupt. Bit 3 reads zero once the request has been taken.
- R9: When bit 12 is set, a bit-3 forced update raises no interrupt. When bit 11 is set, an update forced by `desc_force` raises no interrupt. With bit 11 clear, a `desc_force` update does interrupt.
- R10: `upd_req` holds until `upd_ack`. The cycle after the acknowledge, `irq_req` rises and holds until `irq_ack`. The acknowledge clears the counts, so the next tick-triggered update comes L+1 cycles after the interrupt acknowledge.
- R11: Bits 8:7 drive `status_size` (00 full, 01 64 bytes, 10 32 bytes). Setting them to the undefined value 11 raises a sticky error. The error produces a single one-cycle `attn` pulse one cycle after the write, but only when bit 2 is set.
- R12: `msi_data` is the MSI_BASE parameter with its low three bits replaced by mode bits 6:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wr_data | input | 32 | Mode register write data |
| cfg_rd_data | output | 32 | Mode register read value |
| rx_evt | input | 1 | Receive descriptor completion pulse |
| tx_evt | input | 1 | Transmit descriptor completion pulse |
| desc_force | input | 1 | Force flag carried by a descriptor, one-cycle pulse |
| rx_tick_lim | input | TICK_W | Receive tick threshold, 0 disables |
| tx_tick_lim | input | TICK_W | Transmit tick threshold, 0 disables |
| rx_evt_max | input | EVT_W | Receive pending-event maximum, 0 disables |
| tx_evt_max | input | EVT_W | Transmit pending-event maximum, 0 disables |
| upd_req | output | 1 | Status block write request |
| upd_ack | input | 1 | Status block write done |
| irq_req | output | 1 | Host interrupt request |
| irq_ack | input | 1 | Host interrupt delivered |
| status_size | output | 2 | Selected status block size code |
| msi_data | output | 16 | Interrupt message data word |
| attn | output | 1 | Error attention pulse |

## Verification
The bench builds the block with TICK_W=8, EVT_W=4 and MSI_BASE=16'hA5C0. The 4-bit event counter lets the bench fire the transmit direction at its full-scale maximum of 15 and confirm that 14 events stay silent. The short tick thresholds (2 to 6 cycles) keep the exact L+2 and L+1 latencies, the parked tick counters and the repeat period after an acknowledge inside a few dozen cycles. The chosen MSI_BASE has known low bits, so the substitution of the three low bits is visible.

// File: rtl/coal_pkg.sv
package coal_pkg;

  localparam int MSI_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_UPDATE = 2'd2,
    ST_INTR   = 2'd3
  } coal_state_e;

  typedef struct packed {
    logic             nointr_force;
    logic             nointr_desc;
    logic             park_tx;
    logic             park_rx;
    logic [1:0]       size;
    logic [MSI_W-1:0] msi;
    logic             attn_en;
    logic             run;
  } coal_mode_t;

  localparam logic [1:0] SIZE_UNDEF = 2'b11;

endpackage

// File: rtl/coal_mode_reg.sv
module coal_mode_reg
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        cnow_take,
  input  logic        busy,
  output coal_mode_t  mode,
  output logic        soft_rst,
  output logic        cnow_pend,
  output logic        attn,
  output logic [31:0] rd_data
);

  coal_mode_t mode_q, mode_d;
  logic       srst_q, srst_d;
  logic       cnow_q, cnow_d;
  logic       err_q, err_d;
  logic       attn_q, attn_d;
  logic       err_set;
  logic       unused_rsvd;

  assign unused_rsvd = ^wr_data[31:13];

  always_comb begin
    mode_d = mode_q;
    srst_d = 1'b0;
    cnow_d = cnow_q;
    if (cnow_take || srst_q) cnow_d = 1'b0;
    if (wr_en) begin
      mode_d.run          = wr_data[1];
      mode_d.attn_en      = wr_data[2];
      mode_d.msi          = wr_data[4 +: MSI_W];
      mode_d.size         = wr_data[8:7];
      mode_d.park_rx      = wr_data[9];
      mode_d.park_tx      = wr_data[10];
      mode_d.nointr_desc  = wr_data[11];
      mode_d.nointr_force = wr_data[12];
      srst_d              = wr_data[0];
      if (wr_data[3]) cnow_d = 1'b1;
    end
  end

  assign err_set = (mode_q.size == SIZE_UNDEF) && !err_q && !srst_q;

  always_comb begin
    err_d  = srst_q ? 1'b0 : (err_q | err_set);
    attn_d = err_set & mode_q.attn_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      srst_q <= 1'b0;
      cnow_q <= 1'b0;
      err_q  <= 1'b0;
      attn_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      srst_q <= srst_d;
      cnow_q <= cnow_d;
      err_q  <= err_d;
      attn_q <= attn_d;
    end
  end

  assign mode      = mode_q;
  assign soft_rst  = srst_q;
  assign cnow_pend = cnow_q;
  assign attn      = attn_q;

  assign rd_data = {19'd0, mode_q.nointr_force, mode_q.nointr_desc,
                    mode_q.park_tx, mode_q.park_rx, mode_q.size,
                    mode_q.msi, cnow_q, mode_q.attn_en,
                    mode_q.run | busy, srst_q};

  // R3
  srst_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  // R11
  attn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attn_q |=> !attn_q);

endmodule

// File: rtl/coal_dir_ctr.sv
module coal_dir_ctr #(
  parameter int TICK_W = 16,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              park_mode,
  input  logic              evt,
  input  logic [TICK_W-1:0] tick_lim,
  input  logic [EVT_W-1:0]  evt_max,
  output logic              trig
);

  localparam logic [TICK_W-1:0] TICK_TOP = {TICK_W{1'b1}};
  localparam logic [EVT_W-1:0]  EVT_TOP  = {EVT_W{1'b1}};

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [EVT_W-1:0]  evt_q, evt_d;
  logic              armed_q, armed_d;
  logic              tick_en;

  assign tick_en = run && (armed_q || !park_mode) && (tick_q != TICK_TOP);

  always_comb begin
    if (clr) begin
      tick_d  = '0;
      evt_d   = evt ? EVT_W'(1) : '0;
      armed_d = evt;
    end else begin
      tick_d  = tick_en ? tick_q + 1'b1 : tick_q;
      evt_d   = (evt && evt_q != EVT_TOP) ? evt_q + 1'b1 : evt_q;
      armed_d = armed_q | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      evt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      tick_q  <= tick_d;
      evt_q   <= evt_d;
      armed_q <= armed_d;
    end
  end

  assign trig = ((tick_lim != '0) && (tick_q >= tick_lim)) ||
                ((evt_max != '0) && (evt_q >= evt_max));

  // R7
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (park_mode && !armed_q && !evt && !clr) |=> (tick_q == $past(tick_q)));

endmodule

// File: rtl/coal_fsm.sv
module coal_fsm
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        run,
  input  logic        trig,
  input  logic        cnow_pend,
  input  logic        desc_force,
  input  logic        nointr_force,
  input  logic        nointr_desc,
  input  logic        upd_ack,
  input  logic        irq_ack,
  output coal_state_e state,
  output logic        upd_req,
  output logic        irq_req,
  output logic        cnow_take,
  output logic        ack_clr,
  output logic        busy
);

  coal_state_e st_q, st_d;
  logic        dforce_q, dforce_d;
  logic        want_irq_q, want_irq_d;
  logic        dforce_take;

  always_comb begin
    st_d        = st_q;
    want_irq_d  = want_irq_q;
    cnow_take   = 1'b0;
    dforce_take = 1'b0;
    ack_clr     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (run) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!run) begin
          st_d = ST_IDLE;
        end else if (trig || cnow_pend || dforce_q) begin
          st_d        = ST_UPDATE;
          cnow_take   = cnow_pend;
          dforce_take = dforce_q;
          want_irq_d  = trig || (cnow_pend && !nointr_force) ||
                        (dforce_q && !nointr_desc);
        end
      end
      ST_UPDATE: if (upd_ack) begin
        ack_clr = 1'b1;
        if (want_irq_q) st_d = ST_INTR;
        else            st_d = run ? ST_WAIT : ST_IDLE;
      end
      ST_INTR: if (irq_ack) st_d = run ? ST_WAIT : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (soft_rst) begin
      st_d       = ST_IDLE;
      want_irq_d = 1'b0;
    end
  end

  always_comb begin
    if (soft_rst)         dforce_d = 1'b0;
    else if (desc_force)  dforce_d = 1'b1;
    else if (dforce_take) dforce_d = 1'b0;
    else                  dforce_d = dforce_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      dforce_q   <= 1'b0;
      want_irq_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      dforce_q   <= dforce_d;
      want_irq_q <= want_irq_d;
    end
  end

  assign state   = st_q;
  assign upd_req = (st_q == ST_UPDATE);
  assign irq_req = (st_q == ST_INTR);
  assign busy    = (st_q != ST_IDLE);

  // R10
  upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (upd_req && !upd_ack) |=> upd_req);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (irq_req && !irq_ack) |=> irq_req);

  // R4
  halt_wait_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st_q == ST_WAIT && !run) |=> (st_q == ST_IDLE));

  // R4
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st_q == ST_IDLE) |=> !upd_req);

endmodule

// File: rtl/intr_coal_engine.sv
module intr_coal_engine
  import coal_pkg::*;
#(
  parameter int          TICK_W   = 16,
  parameter int          EVT_W    = 8,
  parameter logic [15:0] MSI_BASE = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rd_data,
  input  logic              rx_evt,
  input  logic              tx_evt,
  input  logic              desc_force,
  input  logic [TICK_W-1:0] rx_tick_lim,
  input  logic [TICK_W-1:0] tx_tick_lim,
  input  logic [EVT_W-1:0]  rx_evt_max,
  input  logic [EVT_W-1:0]  tx_evt_max,
  output logic              upd_req,
  input  logic              upd_ack,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic [1:0]        status_size,
  output logic [15:0]       msi_data,
  output logic              attn
);

  localparam int NDIR = 2;

  logic [1:0]  rst_sync_q;
  logic        rst_core_n;
  coal_mode_t  mode;
  logic        soft_rst, cnow_pend, cnow_take, ack_clr, busy, ctr_clr;
  coal_state_e state;

  logic [NDIR-1:0]   dir_evt, dir_park, dir_trig;
  logic [TICK_W-1:0] dir_lim [NDIR];
  logic [EVT_W-1:0]  dir_max [NDIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  coal_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .cnow_take (cnow_take),
    .busy      (busy),
    .mode      (mode),
    .soft_rst  (soft_rst),
    .cnow_pend (cnow_pend),
    .attn      (attn),
    .rd_data   (cfg_rd_data)
  );

  assign dir_evt  = {tx_evt, rx_evt};
  assign dir_park = {mode.park_tx, mode.park_rx};
  assign dir_lim[0] = rx_tick_lim;
  assign dir_lim[1] = tx_tick_lim;
  assign dir_max[0] = rx_evt_max;
  assign dir_max[1] = tx_evt_max;
  assign ctr_clr  = soft_rst | ack_clr;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    coal_dir_ctr #(.TICK_W(TICK_W), .EVT_W(EVT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .clr       (ctr_clr),
      .run       (state == ST_WAIT),
      .park_mode (dir_park[g]),
      .evt       (dir_evt[g]),
      .tick_lim  (dir_lim[g]),
      .evt_max   (dir_max[g]),
      .trig      (dir_trig[g])
    );
  end

  coal_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .soft_rst     (soft_rst),
    .run          (mode.run),
    .trig         (|dir_trig),
    .cnow_pend    (cnow_pend),
    .desc_force   (desc_force),
    .nointr_force (mode.nointr_force),
    .nointr_desc  (mode.nointr_desc),
    .upd_ack      (upd_ack),
    .irq_ack      (irq_ack),
    .state        (state),
    .upd_req      (upd_req),
    .irq_req      (irq_req),
    .cnow_take    (cnow_take),
    .ack_clr      (ack_clr),
    .busy         (busy)
  );

  assign status_size = mode.size;
  assign msi_data    = {MSI_BASE[15:MSI_W], mode.msi};

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(upd_req && irq_req));

endmodule

// File: tb/tb_intr_coal_engine.sv
`timescale 1ns/1ps
module tb_intr_coal_engine;

  localparam int          TW   = 8;
  localparam int          EW   = 4;
  localparam logic [15:0] BASE = 16'hA5C0;

  localparam logic [31:0] B_RST  = 32'h0000_0001;
  localparam logic [31:0] B_RUN  = 32'h0000_0002;
  localparam logic [31:0] B_ATTN = 32'h0000_0004;
  localparam logic [31:0] B_CNOW = 32'h0000_0008;
  localparam logic [31:0] B_PRX  = 32'h0000_0200;
  localparam logic [31:0] B_PTX  = 32'h0000_0400;
  localparam logic [31:0] B_NID  = 32'h0000_0800;
  localparam logic [31:0] B_NIF  = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en, rx_evt, tx_evt, desc_force, upd_ack, irq_ack;
  logic [31:0] cfg_wr_data, cfg_rd_data;
  logic [TW-1:0] rx_tick_lim, tx_tick_lim;
  logic [EW-1:0] rx_evt_max, tx_evt_max;
  logic upd_req, irq_req, attn;
  logic [1:0] status_size;
  logic [15:0] msi_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  intr_coal_engine #(.TICK_W(TW), .EVT_W(EW), .MSI_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .desc_force(desc_force), .rx_tick_lim(rx_tick_lim), .tx_tick_lim(tx_tick_lim),
    .rx_evt_max(rx_evt_max), .tx_evt_max(tx_evt_max), .upd_req(upd_req),
    .upd_ack(upd_ack), .irq_req(irq_req), .irq_ack(irq_ack),
    .status_size(status_size), .msi_data(msi_data), .attn(attn)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    rx_evt = 1'b0; tx_evt = 1'b0; desc_force = 1'b0;
    upd_ack = 1'b0; irq_ack = 1'b0;
    rx_tick_lim = '0; tx_tick_lim = '0; rx_evt_max = '0; tx_evt_max = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_evt = 1'b1;
    @(negedge clk); rx_evt = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_evt = 1'b1;
    @(negedge clk); tx_evt = 1'b0;
  endtask

  task automatic pulse_force();
    @(negedge clk); desc_force = 1'b1;
    @(negedge clk); desc_force = 1'b0;
  endtask

  task automatic wait_upd(input int lim, output int n);
    n = 0;
    while (!upd_req && n < lim) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic ack_upd();
    upd_ack = 1'b1; @(negedge clk); upd_ack = 1'b0;
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic quiet(input int cyc, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (upd_req) seen = 1'b1;
    end
    check(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(cfg_rd_data == 32'h0, "R1 mode reads zero", cfg_rd_data, 0);
    check({upd_req, irq_req, attn} == 3'b000, "R1 outputs low",
          {upd_req, irq_req, attn}, 0);
  endtask

  task automatic t_reserved();
    do_reset();
    wr(32'hFFFF_E070);
    check(cfg_rd_data == 32'h0000_0070, "R2 reserved bits read zero", cfg_rd_data, 32'h70);
    check(msi_data == {BASE[15:3], 3'b111}, "R12 msi low bits", msi_data, {BASE[15:3], 3'b111});
    wr(32'h0000_0020);
    check(msi_data == {BASE[15:3], 3'b010}, "R12 msi rewrite", msi_data, {BASE[15:3], 3'b010});
  endtask

  task automatic t_tick();
    int n;
    do_reset();
    rx_tick_lim = 8'd6;
    wr(B_RUN);
    wait_upd(40, n);
    check(n == 8, "R5 tick latency L+2", n, 8);
    ack_upd();
    check(irq_req && !upd_req, "R10 interrupt follows update", {upd_req, irq_req}, 2'b01);
    ack_irq();
    check(!irq_req, "R10 interrupt drops on ack", irq_req, 0);
    wait_upd(40, n);
    check(n == 7, "R10 counts cleared, next after L+1", n, 7);
  endtask

  task automatic t_events();
    int n;
    do_reset();
    rx_evt_max = 4'd4;
    wr(B_RUN);
    repeat (3) pulse_rx();
    quiet(6, "R6 rx below maximum");
    pulse_rx();
    wait_upd(5, n);
    check(upd_req && n <= 2, "R6 rx maximum reached", n, 1);
    do_reset();
    tx_evt_max = 4'd15;
    wr(B_RUN);
    repeat (14) pulse_tx();
    quiet(6, "R6 tx below full scale");
    pulse_tx();
    wait_upd(5, n);
    check(upd_req && n <= 2, "R6 tx full-scale maximum", n, 1);
  endtask

  task automatic t_park();
    int n;
    do_reset();
    rx_tick_lim = 8'd4;
    wr(B_RUN | B_PRX);
    quiet(20, "R7 rx ticks parked");
    pulse_rx();
    wait_upd(30, n);
    check(n == 5, "R7 rx ticks start after event", n, 5);
    do_reset();
    tx_tick_lim = 8'd3;
    wr(B_RUN | B_PTX);
    quiet(20, "R7 tx ticks parked");
    pulse_tx();
    wait_upd(30, n);
    check(n == 4, "R7 tx ticks start after event", n, 4);
  endtask

  task automatic t_cnow();
    int n;
    do_reset();
    wr(B_RUN);
    repeat (3) @(negedge clk);
    wr(B_RUN | B_CNOW);
    wait_upd(10, n);
    check(upd_req == 1'b1, "R8 forced update", upd_req, 1);
    check(cfg_rd_data[3] == 1'b0, "R8 bit 3 self-clears", cfg_rd_data[3], 0);
    ack_upd();
    check(irq_req == 1'b1, "R8 forced interrupt", irq_req, 1);
    ack_irq();
  endtask

  task automatic t_nointr();
    int n;
    bit seen;
    do_reset();
    wr(B_RUN | B_NIF);
    wr(B_RUN | B_NIF | B_CNOW);
    wait_upd(10, n);
    check(upd_req == 1'b1, "R9 bit12 update still happens", upd_req, 1);
    ack_upd();
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (irq_req) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R9 bit12 suppresses interrupt", seen, 0);

    do_reset();
    wr(B_RUN | B_NID);
    pulse_force();
    wait_upd(10, n);
    check(upd_req == 1'b1, "R9 descriptor force update", upd_req, 1);
    ack_upd();
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (irq_req) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R9 bit11 suppresses interrupt", seen, 0);

    do_reset();
    wr(B_RUN);
    pulse_force();
    wait_upd(10, n);
    ack_upd();
    check(irq_req == 1'b1, "R9 force interrupts when bit11 clear", irq_req, 1);
    ack_irq();
  endtask

  task automatic t_halt();
    int n;
    do_reset();
    wr(B_RUN);
    wr(B_RUN | B_CNOW);
    wait_upd(10, n);
    wr(32'h0);
    check(upd_req == 1'b1, "R4 update completes after disable", upd_req, 1);
    check(cfg_rd_data[1] == 1'b1, "R4 run reads one while busy", cfg_rd_data[1], 1);
    ack_upd();
    check(irq_req == 1'b1, "R4 interrupt completes after disable", irq_req, 1);
    check(cfg_rd_data[1] == 1'b1, "R4 run reads one in interrupt", cfg_rd_data[1], 1);
    ack_irq();
    check(cfg_rd_data[1] == 1'b0, "R4 run reads zero once stopped", cfg_rd_data[1], 0);
    rx_tick_lim = 8'd2;
    quiet(12, "R4 stopped engine stays quiet");
  endtask

  task automatic t_soft();
    int n;
    do_reset();
    rx_evt_max = 4'd4;
    wr(B_RUN);
    repeat (3) pulse_rx();
    wr(B_RUN | B_RST);
    check(cfg_rd_data[0] == 1'b1, "R3 reset bit visible one cycle", cfg_rd_data[0], 1);
    @(negedge clk);
    check(cfg_rd_data[0] == 1'b0, "R3 reset bit self-clears", cfg_rd_data[0], 0);
    repeat (2) @(negedge clk);
    repeat (3) pulse_rx();
    quiet(6, "R3 pending count cleared");
    pulse_rx();
    wait_upd(5, n);
    check(upd_req == 1'b1, "R3 counting resumes after reset", upd_req, 1);
  endtask

  task automatic t_err();
    bit seen;
    do_reset();
    wr(B_ATTN | 32'h180);
    check(attn == 1'b0, "R11 attn not before error", attn, 0);
    check(status_size == 2'b11, "R11 size output", status_size, 3);
    @(negedge clk);
    check(attn == 1'b1, "R11 attn pulse", attn, 1);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (attn) seen = 1'b1;
    end
    check(!seen, "R11 attn single pulse", seen, 0);
    do_reset();
    wr(32'h180);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (attn) seen = 1'b1;
    end
    check(!seen, "R11 no attn when disabled", seen, 0);
    wr(32'h080);
    check(status_size == 2'b01, "R11 size 64 byte code", status_size, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_reserved();
    t_tick();
    t_events();
    t_park();
    t_cnow();
    t_nointr();
    t_halt();
    t_soft();
    t_err();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule